// File: doc/BRIEF.md
# Keyed-Disarm Watchdog Timer

This block is a watchdog timer for a small microcontroller. Software reaches it through a byte-wide register port, where it programs a 16-bit limit, picks one of two slow tick strobes and arms the timer. Once the timer is armed, a counter advances by one on each strobe from the chosen source. The first warning comes when the count reaches half the limit. It sets a sticky flag, and that flag can drive a level interrupt. When the count reaches the limit, a second sticky flag is set. At the same time the block pulses a reset request for one clock and presents a reset-scope code that software chose in advance. After that request the counter stops until software services the timer.

Software services the timer by writing 1 to the arm bit again. Any write that sets the arm bit clears the counter. Disarming is protected. A write that clears the arm bit takes effect only when bits 7:4 of the same byte carry the key 4'b1001. A stray write therefore cannot stop the timer. Four scratch bytes are provided for software's own use. A limit below 3 is reported as a configuration error and suppresses both events.

Top module: `wdog_timer`

## Requirements
- R1: After reset the timer is disarmed, CTRL (0x00) and SCOPE (0x01) read 0, LIMIT reads 0, STAT (0x08) reads 0x80, and `irq` and `rst_req` are low.
- R2: Register offsets: CTRL 0x00 (bit 0 arm, bit 1 source), SCOPE 0x01 (bits 1:0), IEN 0x04 (bit 0), STAT 0x08, LIMIT low byte 0x0C and high byte 0x0D. Written values read back, and any unmapped offset reads 0.
- R3: While armed, the counter advances by exactly one per strobe of the selected source. CTRL bit 1 = 1 selects `tick_run` and 0 selects `tick_sleep`. Strobes on the other input are ignored.
- R4: STAT bit 0 (halfway flag) sets on the strobe that brings the count to LIMIT >> 1.
- R5: On the strobe that brings the count to LIMIT, STAT bit 1 sets and `rst_req` is high for exactly one cycle. The counter then holds, and further strobes raise no new request until the timer is serviced or disarmed.
- R6: While `rst_req` is high, `rst_kind` equals SCOPE bits 1:0 (0 = all but I/O, 1 = whole chip, 2 = core only).
- R7: Any CTRL write with bit 0 = 1 arms the timer and restarts the count from zero.
- R8: A CTRL write with bit 0 = 0 disarms the timer only if bits 7:4 of that write are 4'b1001. Otherwise the timer stays armed and the count is kept.
- R9: Writing 1 to STAT bit 0 or bit 1 clears that flag, and writing 0 leaves it. When an event and its clear fall in the same cycle, the flag ends up set.
- R10: `irq` is high exactly while the halfway flag and IEN bit 0 are both 1.
- R11: When LIMIT < 3, STAT bit 7 reads 1 and no halfway or limit event occurs, though the counter still runs.
- R12: Scratch bytes at 0x10–0x13 read back what was written, and writing them does not alter the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_run | input | 1 | One-cycle strobe from the always-running slow source |
| tick_sleep | input | 1 | One-cycle strobe from the slow source that stops in sleep |
| bus_sel | input | 1 | Register access valid |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Halfway warning interrupt, level |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 2 | Reset scope presented with the request |

## Verification
Two functions can collide in one cycle: a strobe can produce the halfway event on the same edge where software writes 1 to clear that flag. The bench forces this collision by driving `tick_run` and the STAT write on the same falling edge, after the count has been brought one short of half the limit. It then reads STAT and expects the flag to be set. A second collision, a service write landing on a strobe, is judged by the count of strobes needed before the next request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 5;
  localparam int CNT_W  = 16;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] A_SCOPE  = 5'h01;
  localparam logic [ADDR_W-1:0] A_IEN    = 5'h04;
  localparam logic [ADDR_W-1:0] A_STAT   = 5'h08;
  localparam logic [ADDR_W-1:0] A_LIM_LO = 5'h0C;
  localparam logic [ADDR_W-1:0] A_LIM_HI = 5'h0D;
  localparam int                NOTE_BASE = 16;

  localparam logic [3:0] DISARM_KEY = 4'b1001;

  typedef enum logic [1:0] {
    SCOPE_KEEP_IO = 2'd0,
    SCOPE_CHIP    = 2'd1,
    SCOPE_CORE    = 2'd2,
    SCOPE_SPARE   = 2'd3
  } scope_e;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int NOTE_N    = 4,
  parameter int MIN_LIMIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              hit_half,
  input  logic              hit_full,
  output logic              arm,
  output logic              src_sel,
  output logic              cnt_clr,
  output logic [1:0]        scope,
  output logic              ien,
  output logic              flag_half,
  output logic              flag_rst,
  output logic [CNT_W-1:0]  limit,
  output logic              limit_ok,
  output logic [7:0]        rdata
);
  localparam logic [CNT_W-1:0] LIM_MIN = CNT_W'(MIN_LIMIT);

  logic wr_ctrl, wr_scope, wr_ien, wr_stat, wr_lo, wr_hi;
  logic arm_q, arm_d, src_q, src_d, ien_q, ien_d;
  logic half_q, half_d, frst_q, frst_d;
  logic [1:0]       scope_q, scope_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic [7:0]       note_q [NOTE_N];

  always_comb begin
    wr_ctrl  = bus_sel && bus_wr && (bus_addr == A_CTRL);
    wr_scope = bus_sel && bus_wr && (bus_addr == A_SCOPE);
    wr_ien   = bus_sel && bus_wr && (bus_addr == A_IEN);
    wr_stat  = bus_sel && bus_wr && (bus_addr == A_STAT);
    wr_lo    = bus_sel && bus_wr && (bus_addr == A_LIM_LO);
    wr_hi    = bus_sel && bus_wr && (bus_addr == A_LIM_HI);
  end

  // next state
  always_comb begin
    arm_d = arm_q;
    if (wr_ctrl) begin
      if (bus_wdata[0])                          arm_d = 1'b1;
      else if (bus_wdata[7:4] == DISARM_KEY)     arm_d = 1'b0;
    end
    src_d   = wr_ctrl  ? bus_wdata[1]   : src_q;
    scope_d = wr_scope ? bus_wdata[1:0] : scope_q;
    ien_d   = wr_ien   ? bus_wdata[0]   : ien_q;
    lim_d   = lim_q;
    if (wr_lo) lim_d[7:0]       = bus_wdata;
    if (wr_hi) lim_d[CNT_W-1:8] = bus_wdata;
    // an event in the same cycle as its clear wins
    half_d = (half_q & ~(wr_stat & bus_wdata[0])) | hit_half;
    frst_d = (frst_q & ~(wr_stat & bus_wdata[1])) | hit_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q   <= 1'b0;
      src_q   <= 1'b0;
      scope_q <= 2'd0;
      ien_q   <= 1'b0;
      lim_q   <= '0;
      half_q  <= 1'b0;
      frst_q  <= 1'b0;
    end else begin
      arm_q   <= arm_d;
      src_q   <= src_d;
      scope_q <= scope_d;
      ien_q   <= ien_d;
      lim_q   <= lim_d;
      half_q  <= half_d;
      frst_q  <= frst_d;
    end
  end

  generate
    for (genvar i = 0; i < NOTE_N; i++) begin : g_note
      logic note_we;
      assign note_we = bus_sel && bus_wr && (bus_addr == ADDR_W'(NOTE_BASE + i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       note_q[i] <= 8'h00;
        else if (note_we) note_q[i] <= bus_wdata;
      end
    end
  endgenerate

  always_comb begin
    limit_ok = (lim_q >= LIM_MIN);
    rdata    = 8'h00;
    case (bus_addr)
      A_CTRL:   rdata = {6'b0, src_q, arm_q};
      A_SCOPE:  rdata = {6'b0, scope_q};
      A_IEN:    rdata = {7'b0, ien_q};
      A_STAT:   rdata = {~limit_ok, 5'b0, frst_q, half_q};
      A_LIM_LO: rdata = lim_q[7:0];
      A_LIM_HI: rdata = lim_q[CNT_W-1:8];
      default: begin
        for (int i = 0; i < NOTE_N; i++)
          if (bus_addr == ADDR_W'(NOTE_BASE + i)) rdata = note_q[i];
      end
    endcase
  end

  assign arm       = arm_q;
  assign src_sel   = src_q;
  assign cnt_clr   = wr_ctrl && (bus_wdata[0] || (bus_wdata[7:4] == DISARM_KEY));
  assign scope     = scope_q;
  assign ien       = ien_q;
  assign flag_half = half_q;
  assign flag_rst  = frst_q;
  assign limit     = lim_q;
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             tick,
  input  logic             clr,
  input  logic             limit_ok,
  input  logic [CNT_W-1:0] limit,
  input  logic [1:0]       scope,
  output logic             hit_half,
  output logic             hit_full,
  output logic             rst_req,
  output logic [1:0]       rst_kind,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             held_q, held_d;
  logic             req_q, req_d;
  logic [1:0]       kind_q, kind_d;
  logic             step;

  always_comb begin
    step     = arm && tick && !held_q && !clr && (cnt_q != CNT_MAX);
    cnt_inc  = cnt_q + 1'b1;
    hit_half = step && limit_ok && (cnt_inc == (limit >> 1));
    hit_full = step && limit_ok && (cnt_inc == limit);

    cnt_d  = cnt_q;
    held_d = held_q;
    if (clr || !arm) begin
      cnt_d  = '0;
      held_d = 1'b0;
    end else if (step) begin
      cnt_d  = cnt_inc;
      held_d = hit_full;
    end
    req_d  = hit_full;
    kind_d = hit_full ? scope : kind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= 1'b0;
      req_q  <= 1'b0;
      kind_q <= 2'd0;
    end else begin
      cnt_q  <= cnt_d;
      held_q <= held_d;
      req_q  <= req_d;
      kind_q <= kind_d;
    end
  end

  assign rst_req  = req_q;
  assign rst_kind = kind_q;
  assign cnt      = cnt_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int NOTE_N      = 4,
  parameter int MIN_LIMIT   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_run,
  input  logic              tick_sleep,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              rst_req,
  output logic [1:0]        rst_kind
);
  logic             rst_sync_n;
  logic             arm, src_sel, cnt_clr, ien, flag_half, flag_rst, limit_ok;
  logic [1:0]       scope;
  logic [CNT_W-1:0] limit, cnt;
  logic             hit_half, hit_full, tick_sel;

  wdog_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign tick_sel = src_sel ? tick_run : tick_sleep;

  wdog_regs #(.NOTE_N(NOTE_N), .MIN_LIMIT(MIN_LIMIT)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .hit_half(hit_half), .hit_full(hit_full),
    .arm(arm), .src_sel(src_sel), .cnt_clr(cnt_clr), .scope(scope), .ien(ien),
    .flag_half(flag_half), .flag_rst(flag_rst), .limit(limit), .limit_ok(limit_ok),
    .rdata(bus_rdata)
  );

  wdog_count u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .arm(arm), .tick(tick_sel), .clr(cnt_clr),
    .limit_ok(limit_ok), .limit(limit), .scope(scope),
    .hit_half(hit_half), .hit_full(hit_full),
    .rst_req(rst_req), .rst_kind(rst_kind), .cnt(cnt)
  );

  assign irq = flag_half & ien;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
  import wdog_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              arm,
  input logic [CNT_W-1:0]  cnt,
  input logic              rst_req,
  input logic [1:0]        rst_kind,
  input logic [1:0]        scope,
  input logic              flag_rst,
  input logic              limit_ok
);
  logic keyed_stop;
  assign keyed_stop = bus_sel && bus_wr && (bus_addr == A_CTRL) &&
                      !bus_wdata[0] && (bus_wdata[7:4] == DISARM_KEY);

  // R3: count only moves by one or returns to zero
  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + 1'b1));

  // R5: request comes with its sticky flag
  p_req_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> flag_rst);

  // R5: request lasts one cycle
  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R6: scope code accompanies request
  p_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (rst_kind == scope));

  // R8: disarm only through keyed write
  p_keyed_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arm) |-> $past(keyed_stop));

  // R11: no request from an invalid limit
  p_bad_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(limit_ok));
endmodule

bind wdog_timer wdog_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .arm(arm), .cnt(cnt), .rst_req(rst_req), .rst_kind(rst_kind),
  .scope(scope), .flag_rst(flag_rst), .limit_ok(limit_ok)
);

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       tick_run = 1'b0, tick_sleep = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = 5'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, rst_req;
  logic [1:0] rst_kind;

  int  n_chk = 0, n_err = 0;
  bit  done = 1'b0;
  bit  req_seen;
  int  req_count;

  always #2.5 clk = ~clk;

  wdog_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_run(tick_run), .tick_sleep(tick_sleep),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req), .rst_kind(rst_kind)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // one strobe; req_seen holds rst_req just after the edge that took it
  task automatic tk(input bit s);
    @(negedge clk);
    if (s) tick_run = 1'b1; else tick_sleep = 1'b1;
    @(negedge clk);
    tick_run = 1'b0; tick_sleep = 1'b0;
    req_seen = rst_req;
    if (rst_req) req_count++;
  endtask

  task automatic setup(input int lim, input bit s, input int sc);
    wr(5'h0C, 8'(lim));
    wr(5'h0D, 8'(lim >> 8));
    wr(5'h01, 8'(sc));
    wr(5'h08, 8'h03);
    wr(5'h00, {6'b0, s, 1'b1});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(5'h00, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    rd(5'h01, v); chk(v == 8'h00, "R1 scope", v, 0);
    rd(5'h08, v); chk(v == 8'h80, "R1 stat", v, 8'h80);
    rd(5'h0C, v); chk(v == 8'h00, "R1 limit", v, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(rst_req == 1'b0, "R1 rst_req", rst_req, 0);

    // R2 map and readback
    wr(5'h01, 8'h02); rd(5'h01, v); chk(v == 8'h02, "R2 scope", v, 2);
    wr(5'h04, 8'h01); rd(5'h04, v); chk(v == 8'h01, "R2 ien", v, 1);
    wr(5'h04, 8'h00);
    wr(5'h0C, 8'h34); wr(5'h0D, 8'h12);
    rd(5'h0C, v); chk(v == 8'h34, "R2 lim lo", v, 8'h34);
    rd(5'h0D, v); chk(v == 8'h12, "R2 lim hi", v, 8'h12);
    rd(5'h02, v); chk(v == 8'h00, "R2 unmapped 02", v, 0);
    rd(5'h1F, v); chk(v == 8'h00, "R2 unmapped 1f", v, 0);

    // R12 scratch bytes
    for (int i = 0; i < 4; i++) wr(5'(16 + i), 8'(8'hA5 ^ (i * 8'h13)));
    for (int i = 0; i < 4; i++) begin
      rd(5'(16 + i), v);
      chk(v == 8'(8'hA5 ^ (i * 8'h13)), "R12 scratch", v, 8'(8'hA5 ^ (i * 8'h13)));
    end

    // R3 R4 R5 R6 sweep of limits and both sources
    for (int m = 3; m <= 12; m++) begin
      for (int s = 0; s < 2; s++) begin
        setup(m, s[0], m % 3);
        for (int k = 1; k <= m + 2; k++) begin
          tk(~s[0]);           // R3 other source ignored
          chk(rst_req == 1'b0, "R3 other src", rst_req, 0);
          tk(s[0]);
          chk(req_seen == (k == m), "R5 req pulse", req_seen, (k == m));
          if (k == m) chk(rst_kind == 2'(m % 3), "R6 kind", rst_kind, m % 3);
          rd(5'h08, v);
          chk(v[0] == (k >= (m >> 1)), "R4 half flag", v[0], (k >= (m >> 1)));
          chk(v[1] == (k >= m), "R5 rst flag", v[1], (k >= m));
        end
      end
    end

    // R7 service restarts the count
    setup(6, 1'b1, 1);
    repeat (4) tk(1'b1);
    wr(5'h00, 8'h03);
    req_count = 0;
    repeat (5) tk(1'b1);
    chk(req_count == 0, "R7 no req after feed", req_count, 0);
    tk(1'b1);
    chk(req_seen == 1'b1, "R7 req after full period", req_seen, 1);

    // R5 held after request, serviced restart
    req_count = 0;
    repeat (4) tk(1'b1);
    chk(req_count == 0, "R5 held", req_count, 0);

    // R8 keyed disarm
    setup(6, 1'b1, 0);
    repeat (2) tk(1'b1);
    wr(5'h00, 8'h02);
    rd(5'h00, v); chk(v == 8'h03, "R8 no key stays armed", v, 3);
    wr(5'h00, 8'h82);
    rd(5'h00, v); chk(v == 8'h03, "R8 wrong key stays armed", v, 3);
    req_count = 0;
    repeat (3) tk(1'b1);
    chk(req_count == 0, "R8 count kept early", req_count, 0);
    tk(1'b1);
    chk(req_seen == 1'b1, "R8 count kept", req_seen, 1);
    wr(5'h08, 8'h03);
    wr(5'h00, 8'h03);
    wr(5'h00, 8'h92);
    rd(5'h00, v); chk(v == 8'h02, "R8 keyed disarm", v, 2);
    req_count = 0;
    repeat (8) tk(1'b1);
    chk(req_count == 0, "R8 disarmed no req", req_count, 0);
    rd(5'h08, v); chk(v == 8'h00, "R8 disarmed no flags", v, 0);

    // R9 write-one-to-clear
    setup(4, 1'b1, 0);
    repeat (4) tk(1'b1);
    wr(5'h08, 8'h00); rd(5'h08, v); chk(v == 8'h03, "R9 write 0 keeps", v, 3);
    wr(5'h08, 8'h01); rd(5'h08, v); chk(v == 8'h02, "R9 clear half", v, 2);
    wr(5'h08, 8'h02); rd(5'h08, v); chk(v == 8'h00, "R9 clear rst", v, 0);

    // R9 event and clear in the same cycle
    setup(6, 1'b1, 0);
    repeat (2) tk(1'b1);
    @(negedge clk);
    tick_run = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h08; bus_wdata = 8'h01;
    @(negedge clk);
    tick_run = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    rd(5'h08, v); chk(v[0] == 1'b1, "R9 set wins", v[0], 1);
    wr(5'h08, 8'h01); rd(5'h08, v); chk(v[0] == 1'b0, "R9 later clear", v[0], 0);

    // R10 interrupt gating
    setup(6, 1'b1, 0);
    wr(5'h04, 8'h00);
    repeat (3) tk(1'b1);
    @(negedge clk); chk(irq == 1'b0, "R10 masked", irq, 0);
    wr(5'h04, 8'h01);
    @(negedge clk); chk(irq == 1'b1, "R10 raised", irq, 1);
    wr(5'h08, 8'h01);
    @(negedge clk); chk(irq == 1'b0, "R10 cleared", irq, 0);
    wr(5'h04, 8'h00);

    // R12 scratch write mid-count leaves timing
    setup(6, 1'b0, 2);
    repeat (3) tk(1'b0);
    wr(5'h11, 8'h5A);
    req_count = 0;
    repeat (2) tk(1'b0);
    chk(req_count == 0, "R12 timing early", req_count, 0);
    tk(1'b0);
    chk(req_seen == 1'b1, "R12 timing", req_seen, 1);

    // R11 invalid limit
    setup(2, 1'b1, 0);
    req_count = 0;
    repeat (10) tk(1'b1);
    chk(req_count == 0, "R11 no req", req_count, 0);
    rd(5'h08, v); chk(v == 8'h80, "R11 stat", v, 8'h80);
    wr(5'h0C, 8'h03);
    rd(5'h08, v); chk(v == 8'h00, "R11 valid limit", v, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule